// File: doc/BRIEF.md
# Wave Memory Access Coalescer

This block takes a load request from a whole wave of lanes and turns it into the fewest wide memory transactions that cover it. Each lane brings an active bit and a byte address. One size selector for the whole request picks either single-word (4-byte) or four-word (16-byte) accesses. The coalescer groups active lanes whose accesses fall inside the same 128-byte segment aligned on a 128-byte boundary. It emits one transaction per segment touched. So the transaction count follows the address pattern and not the lane count.

A request is taken on a valid/ready handshake while the block is idle. Transactions then leave one per cycle on a second valid/ready handshake. Each one carries the segment base address, a bitmap of the lanes it serves, and a bitmap of the bytes it touches inside the segment. When the last transaction has been taken, a one-cycle completion pulse reports how many transactions the request needed. Only after that pulse is a new request taken. Accesses are assumed to be naturally aligned to their size, so a lane never spans two segments.

Top module: `wave_coalescer`

## Requirements
- R1: With every lane active, word accesses, and lane i at address B + 4*i with B a multiple of 128, the request completes in LANES*4/128 transactions: 1 for 32 lanes and 2 for 64 lanes.
- R2: LANES may be 32 or 64. The same request pattern gives each width its own correct count, and lanes above LANES do not exist.
- R3: A quad access (req_quad = 1) is one request of 16 bytes per lane. txn_bytes bit k stands for byte k of the segment. A quad lane at segment offset o sets bits (o rounded down to 16) through +15, and a word lane sets bits (o rounded down to 4) through +3. Contiguous quads at B + 16*i need LANES*16/128 transactions.
- R4: For any address pattern, including strides of 2 words or more, the transaction count equals the number of distinct 128-byte segments touched by active lanes.
- R5: A lane whose req_mask bit is 0 is never named in txn_lanes and adds no transaction. An all-zero mask completes with done_count = 0 and no txn_valid.
- R6: Each transaction has txn_base equal to the segment of the lowest-numbered active lane not yet served, with its low 7 bits zero. Its txn_lanes (bit i = lane i) holds exactly the active, not-yet-served lanes in that segment.
- R7: Over one request, the txn_lanes of all accepted transactions are pairwise disjoint and their OR equals req_mask.
- R8: While txn_valid is high and txn_ready is low, txn_valid, txn_base and txn_lanes hold their values. One transaction is taken per cycle in which both are high.
- R9: done is a one-cycle pulse in the cycle after the final transaction is taken (the cycle after acceptance when the mask is zero), and done_count equals the number of transactions taken. req_ready is low from acceptance through the done cycle and high again after it.
- R10: After reset, req_ready is 1 and txn_valid and done are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Wave request offered |
| req_ready | output | 1 | Block idle; a request is taken when both are high |
| req_mask | input | LANES | Active lane bits |
| req_addr | input | LANES*ADDR_W | Byte address of lane i in bits [i*ADDR_W +: ADDR_W] |
| req_quad | input | 1 | 0: 4-byte access per lane, 1: 16-byte access per lane |
| txn_valid | output | 1 | Transaction offered |
| txn_ready | input | 1 | Transaction taken when both are high |
| txn_base | output | ADDR_W | Segment base address, 128-byte aligned |
| txn_lanes | output | LANES | Lanes served by this transaction |
| txn_bytes | output | SEG_BYTES | Bytes of the segment touched |
| done | output | 1 | One-cycle completion pulse |
| done_count | output | $clog2(LANES+1) | Transactions issued for the last request |

## Verification
A wrong pending-lane state shows up at the ports in the very transaction it affects. A lane dropped too early goes missing from the OR of txn_lanes. A lane left pending appears twice or holds back done. A lane taken out of order gives a txn_base that differs from the segment of the lowest unserved lane. A wrong counter or completion condition shows one cycle later as an early, late or missing done pulse, or as a done_count that disagrees with the number of handshakes. Two widths run side by side under the same stimulus, so a width-dependent slice error shows as one of them disagreeing with its own computed count.

// File: rtl/wave_coal_pkg.sv
// Shared types for the wave coalescer.
// Assumes: nothing beyond IEEE 1800-2017 enums.
package wave_coal_pkg;

    // Per-request access size.
    typedef enum logic {
        ACC_WORD = 1'b0,
        ACC_QUAD = 1'b1
    } acc_size_e;

    // Controller state.
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } coal_state_e;

endpackage

// File: rtl/wave_coal_leader.sv
// Leader pick: isolates the lowest pending lane and returns its address.
// Assumes: pend is the set of lanes still to be served; when pend is zero,
// any_pend is 0 and lead_addr is 0.
module wave_coal_leader #(
    parameter int LANES  = 32,
    parameter int ADDR_W = 32
) (
    input  logic [LANES-1:0]        pend,
    input  logic [LANES*ADDR_W-1:0] addr_flat,
    output logic [ADDR_W-1:0]       lead_addr,
    output logic                    any_pend
);

    logic [LANES-1:0] lead_onehot;

    // Lowest set bit of the pending set, as a one-hot vector.
    assign lead_onehot = pend & (~pend + {{(LANES-1){1'b0}}, 1'b1});
    assign any_pend    = |pend;

    // One-hot select of the leader's address.
    always_comb begin
        lead_addr = '0;
        for (int i = 0; i < LANES; i++) begin
            lead_addr = lead_addr | (addr_flat[i*ADDR_W +: ADDR_W] & {ADDR_W{lead_onehot[i]}});
        end
    end

endmodule

// File: rtl/wave_coal_match.sv
// Segment match: marks every pending lane whose address lies in the given
// segment and builds the byte map of the bytes those lanes touch.
// Assumes: accesses are naturally aligned; low address bits below the access
// size are ignored. The byte map is built at word granularity.
module wave_coal_match #(
    parameter int LANES     = 32,
    parameter int ADDR_W    = 32,
    parameter int SEG_BYTES = 128,
    localparam int SEG_SHIFT = $clog2(SEG_BYTES),
    localparam int WORDS     = SEG_BYTES / 4,
    localparam int WIDX_W    = SEG_SHIFT - 2
) (
    input  logic [LANES-1:0]          pend,
    input  logic [LANES*ADDR_W-1:0]   addr_flat,
    input  logic                      quad,
    input  logic [ADDR_W-SEG_SHIFT-1:0] seg,
    output logic [LANES-1:0]          hit,
    output logic [SEG_BYTES-1:0]      bytes
);

    logic [WORDS-1:0] lane_words [LANES];
    logic [WORDS-1:0] word_en;

    for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
        logic [ADDR_W-1:0] a;
        logic [WIDX_W-1:0] start;
        assign a = addr_flat[gi*ADDR_W +: ADDR_W];
        // Lane belongs to this transaction when pending and in the segment.
        assign hit[gi] = pend[gi] && (a[ADDR_W-1:SEG_SHIFT] == seg);
        // First word of the access: a quad access starts on a 4-word boundary.
        assign start = quad ? {a[SEG_SHIFT-1:4], 2'b00} : a[SEG_SHIFT-1:2];
        // Words covered by this lane, zero when the lane is not served.
        assign lane_words[gi] = hit[gi]
            ? ((quad ? WORDS'(4'hF) : WORDS'(1)) << start)
            : '0;
    end

    // Union of all served lanes' words.
    always_comb begin
        word_en = '0;
        for (int i = 0; i < LANES; i++) begin
            word_en = word_en | lane_words[i];
        end
    end

    for (genvar gw = 0; gw < WORDS; gw++) begin : g_byte
        assign bytes[gw*4 +: 4] = {4{word_en[gw]}};
    end

endmodule

// File: rtl/wave_coalescer.sv
// Wave coalescer top: captures one wave request, then emits one transaction
// per distinct aligned segment, leader-first, one per accepted cycle, and
// pulses done with the transaction count.
// Assumes: LANES is 32 or 64; accesses naturally aligned to 4 or 16 bytes;
// synchronous active-low reset.
module wave_coalescer
    import wave_coal_pkg::*;
#(
    parameter int LANES     = 32,
    parameter int ADDR_W    = 32,
    parameter int SEG_BYTES = 128,
    localparam int CNT_W     = $clog2(LANES + 1),
    localparam int SEG_SHIFT = $clog2(SEG_BYTES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [LANES-1:0]        req_mask,
    input  logic [LANES*ADDR_W-1:0] req_addr,
    input  logic                    req_quad,
    output logic                    txn_valid,
    input  logic                    txn_ready,
    output logic [ADDR_W-1:0]       txn_base,
    output logic [LANES-1:0]        txn_lanes,
    output logic [SEG_BYTES-1:0]    txn_bytes,
    output logic                    done,
    output logic [CNT_W-1:0]        done_count
);

    coal_state_e             state_q;
    acc_size_e               size_q;
    logic [LANES-1:0]        mask_q;
    logic [LANES-1:0]        pend_q;
    logic [LANES*ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]        count_q;

    logic [ADDR_W-1:0] lead_addr;
    logic              any_pend;
    logic [LANES-1:0]  hit;
    logic              busy;
    logic              fire;

    wave_coal_leader #(
        .LANES  (LANES),
        .ADDR_W (ADDR_W)
    ) u_leader (
        .pend      (pend_q),
        .addr_flat (addr_q),
        .lead_addr (lead_addr),
        .any_pend  (any_pend)
    );

    wave_coal_match #(
        .LANES     (LANES),
        .ADDR_W    (ADDR_W),
        .SEG_BYTES (SEG_BYTES)
    ) u_match (
        .pend      (pend_q),
        .addr_flat (addr_q),
        .quad      (size_q == ACC_QUAD),
        .seg       (lead_addr[ADDR_W-1:SEG_SHIFT]),
        .hit       (hit),
        .bytes     (txn_bytes)
    );

    // Handshake and output decode.
    assign busy       = (state_q == ST_BUSY);
    assign req_ready  = (state_q == ST_IDLE);
    assign txn_valid  = busy && any_pend;
    assign txn_lanes  = hit;
    assign txn_base   = {lead_addr[ADDR_W-1:SEG_SHIFT], {SEG_SHIFT{1'b0}}};
    assign done       = busy && !any_pend;
    assign done_count = count_q;
    assign fire       = txn_valid && txn_ready;

    // Request capture, pending-lane retirement and transaction counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            size_q  <= ACC_WORD;
            mask_q  <= '0;
            pend_q  <= '0;
            addr_q  <= '0;
            count_q <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        mask_q  <= req_mask;
                        pend_q  <= req_mask;
                        addr_q  <= req_addr;
                        size_q  <= acc_size_e'(req_quad);
                        count_q <= '0;
                        state_q <= ST_BUSY;
                    end
                end
                ST_BUSY: begin
                    if (fire) begin
                        pend_q  <= pend_q & ~hit;
                        count_q <= count_q + 1'b1;
                    end
                    if (done) begin
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/wave_coalescer_checker.sv
// Protocol and coverage checker for wave_coalescer, attached by bind.
// Keeps its own record of lanes served in the current request.
module wave_coalescer_checker #(
    parameter int LANES  = 32,
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              txn_valid,
    input logic              txn_ready,
    input logic [ADDR_W-1:0] txn_base,
    input logic [LANES-1:0]  txn_lanes,
    input logic              done,
    input logic [LANES-1:0]  mask_q
);

    logic [LANES-1:0] served;

    // Lanes served so far in the current request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            served <= '0;
        end else if (req_valid && req_ready) begin
            served <= '0;
        end else if (txn_valid && txn_ready) begin
            served <= served | txn_lanes;
        end
    end

    assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && !txn_ready) |=> (txn_valid && $stable(txn_base) && $stable(txn_lanes)));

    assert_base_aligned_R6: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |-> (txn_base[6:0] == 7'd0 && txn_lanes != '0));

    assert_lanes_in_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |-> ((txn_lanes & ~mask_q) == '0));

    assert_no_overlap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |-> ((txn_lanes & served) == '0));

    assert_full_cover_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (served == mask_q));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_busy_after_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    assert_done_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!txn_valid && !req_ready));

endmodule

bind wave_coalescer wave_coalescer_checker #(
    .LANES  (LANES),
    .ADDR_W (ADDR_W)
) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .txn_valid (txn_valid),
    .txn_ready (txn_ready),
    .txn_base  (txn_base),
    .txn_lanes (txn_lanes),
    .done      (done),
    .mask_q    (mask_q)
);

// File: tb/wave_coalescer_bench.sv
`timescale 1ns/1ps
// Runs a 32-lane and a 64-lane coalescer side by side on shared stimulus
// and checks every transaction against an arithmetic model.
module wave_coalescer_bench;

    localparam int AW = 32;
    localparam int NW = 64;
    localparam int SB = 128;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic              req_valid = 1'b0;
    logic [NW-1:0]     drv_m = '0;
    logic [NW*AW-1:0]  drv_flat = '0;
    logic              drv_q = 1'b0;
    logic              txn_ready = 1'b0;
    logic [AW-1:0]     da [NW];

    logic              rdy0, v0, dn0, rdy1, v1, dn1;
    logic [AW-1:0]     base0, base1;
    logic [31:0]       lanes0;
    logic [63:0]       lanes1;
    logic [SB-1:0]     bytes0, bytes1;
    logic [5:0]        cnt0;
    logic [6:0]        cnt1;

    wave_coalescer #(.LANES(32), .ADDR_W(AW), .SEG_BYTES(SB)) u_wave_coalescer (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy0),
        .req_mask(drv_m[31:0]), .req_addr(drv_flat[32*AW-1:0]), .req_quad(drv_q),
        .txn_valid(v0), .txn_ready(txn_ready), .txn_base(base0), .txn_lanes(lanes0),
        .txn_bytes(bytes0), .done(dn0), .done_count(cnt0));

    wave_coalescer #(.LANES(64), .ADDR_W(AW), .SEG_BYTES(SB)) u_wave_coalescer_w64 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy1),
        .req_mask(drv_m), .req_addr(drv_flat), .req_quad(drv_q),
        .txn_valid(v1), .txn_ready(txn_ready), .txn_base(base1), .txn_lanes(lanes1),
        .txn_bytes(bytes1), .done(dn1), .done_count(cnt1));

    logic          o_rdy [2];
    logic          o_v   [2];
    logic          o_dn  [2];
    logic [AW-1:0] o_base[2];
    logic [63:0]   o_lanes[2];
    logic [SB-1:0] o_bytes[2];
    logic [6:0]    o_cnt [2];
    assign o_rdy[0] = rdy0;   assign o_rdy[1] = rdy1;
    assign o_v[0]   = v0;     assign o_v[1]   = v1;
    assign o_dn[0]  = dn0;    assign o_dn[1]  = dn1;
    assign o_base[0] = base0; assign o_base[1] = base1;
    assign o_lanes[0] = {32'd0, lanes0}; assign o_lanes[1] = lanes1;
    assign o_bytes[0] = bytes0; assign o_bytes[1] = bytes1;
    assign o_cnt[0] = {1'b0, cnt0}; assign o_cnt[1] = cnt1;

    // Model state for the request in flight.
    logic [AW-1:0] ea [NW];
    logic [NW-1:0] em;
    logic          eq;
    logic [63:0]   cov [2];
    int            hs [2];
    int            last_hs [2];
    int            done_it [2];
    bit            seen [2];
    bit            busy_bad [2];

    int n_checks = 0;
    int n_err = 0;
    logic [31:0] seed = 32'h1234_5678;

    function automatic logic [31:0] rnd();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        return seed;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Number of distinct 128-byte segments among the first n active lanes.
    function automatic int exp_count(input int n);
        int c = 0;
        for (int i = 0; i < n; i++) begin
            bit dup = 0;
            if (em[i]) begin
                for (int j = 0; j < i; j++)
                    if (em[j] && ea[j][31:7] == ea[i][31:7]) dup = 1;
                if (!dup) c++;
            end
        end
        return c;
    endfunction

    // Compare one accepted transaction with the leader-first model.
    task automatic on_txn(input int d, input int n, input int it);
        int lead = -1;
        logic [24:0]  sg;
        logic [63:0]  el = '0;
        logic [127:0] eb = '0;
        for (int j = 0; j < n; j++)
            if (em[j] && !cov[d][j] && lead < 0) lead = j;
        if (lead < 0) begin
            check(0, "R7", "transaction after all lanes served", o_lanes[d], 0);
        end else begin
            sg = ea[lead][31:7];
            for (int j = 0; j < n; j++) begin
                if (em[j] && !cov[d][j] && ea[j][31:7] == sg) begin
                    int off = int'(ea[j][6:0]);
                    int len = eq ? 16 : 4;
                    el[j] = 1'b1;
                    off = eq ? (off & ~15) : (off & ~3);
                    for (int k = 0; k < len; k++) eb[off+k] = 1'b1;
                end
            end
            check(o_base[d] == {sg, 7'd0}, "R6", "txn_base", o_base[d], {sg, 7'd0});
            check(o_lanes[d] == el, "R6", "txn_lanes", o_lanes[d], el);
            check(o_bytes[d] == eb, "R3", "txn_bytes", o_bytes[d], eb);
        end
        cov[d] = cov[d] | o_lanes[d];
        hs[d]++;
        last_hs[d] = it;
    endtask

    task automatic pack();
        for (int i = 0; i < NW; i++) drv_flat[i*AW +: AW] = da[i];
    endtask

    // Issue the driven request to both widths and follow it to done.
    task automatic run_case(input string tag, input bit hammer, input bit backp);
        int it = 0;
        for (int i = 0; i < NW; i++) ea[i] = da[i];
        em = drv_m;
        eq = drv_q;
        for (int d = 0; d < 2; d++) begin
            cov[d] = '0; hs[d] = 0; last_hs[d] = 0; done_it[d] = 0;
            seen[d] = 0; busy_bad[d] = 0;
        end
        @(negedge clk);
        pack();
        req_valid = 1'b1;
        while (!(seen[0] && seen[1]) && it < 400) begin
            @(negedge clk);
            it++;
            if (hammer) begin
                drv_m = '1;
                for (int i = 0; i < NW; i++) da[i] = rnd();
                pack();
            end else begin
                req_valid = 1'b0;
            end
            txn_ready = backp ? (seed[0] | seed[3]) : 1'b1;
            void'(rnd());
            #1;
            for (int d = 0; d < 2; d++) begin
                int n = (d == 0) ? 32 : 64;
                if (!seen[d]) begin
                    if (o_rdy[d]) busy_bad[d] = 1;
                    if (o_v[d] && txn_ready) on_txn(d, n, it);
                    if (o_dn[d]) begin
                        seen[d] = 1;
                        done_it[d] = it;
                    end
                end
            end
            if (seen[0] || seen[1]) req_valid = 1'b0;
        end
        req_valid = 1'b0;
        for (int d = 0; d < 2; d++) begin
            int n = (d == 0) ? 32 : 64;
            int ec = exp_count(n);
            logic [63:0] mm = (d == 0) ? {32'd0, em[31:0]} : em;
            int edi = (hs[d] == 0) ? 1 : last_hs[d] + 1;
            check(seen[d], "R9", "done seen", seen[d], 1);
            check(int'(o_cnt[d]) == ec, tag, "done_count vs distinct segments", o_cnt[d], ec);
            check(hs[d] == ec, "R8", "handshakes taken", hs[d], ec);
            check(cov[d] == mm, "R7", "union of txn_lanes", cov[d], mm);
            check(done_it[d] == edi, "R9", "done cycle", done_it[d], edi);
            check(!busy_bad[d], "R9", "req_ready low while busy", busy_bad[d], 0);
        end
        @(negedge clk);
        #1;
        for (int d = 0; d < 2; d++) begin
            check(o_rdy[d] && !o_dn[d], "R9", "idle after done", {o_rdy[d], o_dn[d]}, 2'b10);
        end
    endtask

    task automatic set_stride(input logic [31:0] b, input int step, input bit q,
                              input logic [63:0] m);
        for (int i = 0; i < NW; i++) da[i] = b + 32'(step * i);
        drv_m = m;
        drv_q = q;
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_err++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        for (int i = 0; i < NW; i++) da[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        for (int d = 0; d < 2; d++)
            check(o_rdy[d] && !o_v[d] && !o_dn[d], "R10", "reset state",
                  {o_rdy[d], o_v[d], o_dn[d]}, 3'b100);

        // R1 / R2: contiguous words.
        set_stride(32'h1000_0000, 4, 0, '1);
        run_case("R1", 0, 0);
        check(cnt0 == 6'd1, "R1", "32-lane contiguous count", cnt0, 1);
        check(cnt1 == 7'd2, "R2", "64-lane contiguous count", cnt1, 2);

        // R3: contiguous quads.
        set_stride(32'h2000_0000, 16, 1, '1);
        run_case("R3", 0, 0);
        check(cnt0 == 6'd4, "R3", "32-lane quad count", cnt0, 4);
        check(cnt1 == 7'd8, "R3", "64-lane quad count", cnt1, 8);

        // R4: stride of 2 words and of one segment.
        set_stride(32'h3000_0000, 8, 0, '1);
        run_case("R4", 0, 1);
        check(cnt0 == 6'd2, "R4", "stride-2 count 32", cnt0, 2);
        check(cnt1 == 7'd4, "R4", "stride-2 count 64", cnt1, 4);
        set_stride(32'h3100_0000, 128, 0, '1);
        run_case("R4", 0, 0);
        check(cnt0 == 6'd32, "R4", "per-lane segment count 32", cnt0, 32);

        // R5: zero mask, and a mask that skips whole segments.
        set_stride(32'h4000_0000, 4, 0, '0);
        run_case("R5", 0, 0);
        check(cnt0 == 6'd0 && cnt1 == 7'd0, "R5", "zero mask count", {cnt0, cnt1}, 0);
        set_stride(32'h4100_0000, 4, 0, 64'h0000_0000_FFFF_0000);
        run_case("R5", 0, 0);
        check(cnt1 == 7'd1, "R5", "upper-half lanes inactive", cnt1, 1);

        // Unaligned base spans two segments; request hammered while busy.
        set_stride(32'h5000_0040, 4, 0, '1);
        run_case("R4", 1, 1);
        check(cnt0 == 6'd2, "R4", "half-offset contiguous count", cnt0, 2);

        // Random sweep with colliding addresses.
        for (int c = 0; c < 200; c++) begin
            logic [31:0] span = (c % 3 == 0) ? 32'h3FF : 32'h1FFF;
            drv_q = c[0];
            for (int i = 0; i < NW; i++) begin
                logic [31:0] r = 32'h6000_0000 + (rnd() & span);
                da[i] = drv_q ? (r & ~32'hF) : (r & ~32'h3);
            end
            drv_m = {rnd(), rnd()};
            if (c % 4 == 1) drv_m = drv_m & {rnd(), rnd()};
            run_case("R4", c % 5 == 2, c % 2 == 1);
        end

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule